// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns a pair of parallel stereo sample words into a serial audio stream. It runs on a fast system clock. It samples an incoming master bit clock and frame word-select line, and from them it produces a divided output bit clock, an output word-select line and a serial data line. Serial data and word select change only on falling edges of the output bit clock, so a receiver can capture them on the rising edge.

Four framings can be chosen at run time: standard I2S and three LSB-justified widths. The output bit clock can be the incoming bit clock or that clock divided by 2, 4 or 8. Word select can follow the input line, or the block can regenerate it with an exact 50% duty cycle. A new configuration and a new sample pair are picked up only at the start of a frame, which is where the left slot begins. The output is muted whenever the incoming bit clock or word select stops.

Top module: `ser_audio_tx`

## Requirements
- R1: While reset is held and right after it is released, `sdata_out`, `bclk_out` and `ws_out` are all low.
- R2: The `div_sel` field sets the length of one `bclk_out` period in incoming bit-clock periods: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: With `ws_regen` low, `ws_out` copies the incoming word select as sampled at falling edges of `bclk_out`, so each slot lasts as long as the matching half of the input frame.
- R4: With `ws_regen` high, `ws_out` toggles every `SLOT_BITS` periods of `bclk_out` (default 32), which gives a 50% duty cycle whatever the input frame looks like.
- R5: Format 00 (I2S): the left word is sent while `ws_out` is low. Its MSB appears one `bclk_out` period after the `ws_out` transition, followed by all `DATA_W` bits and then zeros for the rest of the slot.
- R6: Formats 01, 10 and 11 are LSB-justified at 16, 18 and 20 bits, and each sends the top N bits of the sample. The LSB occupies the last bit period before the next `ws_out` transition. Every earlier slot position repeats the sample's sign bit.
- R7: Apart from muting, `sdata_out` and `ws_out` change only in the cycle in which `bclk_out` falls.
- R8: `fmt_sel`, `div_sel`, `ws_regen` and both sample words are captured together at the `ws_out` falling transition. A change in the middle of a frame therefore leaves that frame in its old form.
- R9: `sdata_out` is forced low while the input bit clock has shown no edge for `BCLK_TMO` system cycles, or the input word select has shown no transition for `WS_TMO` input bit-clock periods. Output resumes once both are present again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Incoming master bit clock |
| ws_in | input | 1 | Incoming frame word select |
| left_smp | input | DATA_W | Left-channel sample, MSB-aligned two's complement |
| right_smp | input | DATA_W | Right-channel sample, MSB-aligned two's complement |
| fmt_sel | input | 2 | Framing: 00 I2S, 01/10/11 LSB-justified 16/18/20 |
| div_sel | input | 2 | Bit-clock divider: 00 /1, 01 /2, 10 /4, 11 /8 |
| ws_regen | input | 1 | 0 pass word select through, 1 regenerate at 50% duty |
| sdata_out | output | 1 | Serial data |
| bclk_out | output | 1 | Divided output bit clock |
| ws_out | output | 1 | Output word select |

## Verification
On every cycle, the assertions check that serial data and word select move only when the output bit clock falls. They also check that the output bit clock toggles only on an input bit-clock edge, that the active configuration changes only at a frame start, and that a stalled input bit clock mutes the output. The bench's scenarios are needed for everything else. They decode whole frames as a receiver would, then check the bit order of each framing, the sign-extension fill, the divided clock period, the slot lengths in both word-select modes, whether a change in mid-frame is deferred, and whether the output recovers after a stall.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

    typedef enum logic [1:0] {
        FMT_STD  = 2'b00,
        FMT_LJ16 = 2'b01,
        FMT_LJ18 = 2'b10,
        FMT_LJ20 = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] div;
        logic       regen;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{fmt: FMT_STD, div: 2'b00, regen: 1'b0};

    // payload width of an LSB-justified framing
    function automatic int lj_bits(fmt_e f);
        case (f)
            FMT_LJ16: return 16;
            FMT_LJ18: return 18;
            default:  return 20;
        endcase
    endfunction

endpackage

// File: rtl/sas_in_sense.sv
module sas_in_sense #(
    parameter int BCLK_TMO = 64,
    parameter int WS_TMO   = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic ws_in,
    output logic bclk_edge,
    output logic ws_lvl,
    output logic live
);
    localparam int BT_W = $clog2(BCLK_TMO + 1);
    localparam int WT_W = $clog2(WS_TMO + 1);
    localparam logic [BT_W-1:0] BT_LIM = BT_W'(BCLK_TMO);
    localparam logic [WT_W-1:0] WT_LIM = WT_W'(WS_TMO);

    typedef struct packed {
        logic [2:0]      bs;
        logic [2:0]      wsv;
        logic [BT_W-1:0] bto;
        logic [WT_W-1:0] wto;
        logic            live;
    } st_t;

    st_t st_d, st_q;
    logic b_edge, b_rise, w_edge;

    always_comb begin
        st_d     = st_q;
        b_edge   = st_q.bs[2] ^ st_q.bs[1];
        b_rise   = st_q.bs[1] & ~st_q.bs[2];
        w_edge   = st_q.wsv[2] ^ st_q.wsv[1];
        st_d.bs  = {st_q.bs[1:0], bclk_in};
        st_d.wsv = {st_q.wsv[1:0], ws_in};
        if (b_edge)
            st_d.bto = '0;
        else if (st_q.bto != BT_LIM)
            st_d.bto = st_q.bto + 1'b1;
        if (w_edge)
            st_d.wto = '0;
        else if (b_rise && st_q.wto != WT_LIM)
            st_d.wto = st_q.wto + 1'b1;
        st_d.live = (st_d.bto != BT_LIM) && (st_d.wto != WT_LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_edge = b_edge;
    assign ws_lvl    = st_q.wsv[1];
    assign live      = st_q.live;

    // R9: a stalled bit clock must leave the output muted
    p_stall_mutes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bto == BT_LIM) |-> !live);

endmodule

// File: rtl/sas_bclk_gen.sv
module sas_bclk_gen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_edge,
    input  logic [DIV_W-1:0] div_act,
    output logic             bclk_o,
    output logic             fall_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic hit;

    always_comb begin
        st_d = st_q;
        lim  = CNT_W'((1 << div_act) - 1);
        hit  = in_edge && (st_q.cnt >= lim);
        if (in_edge) begin
            if (hit) begin
                st_d.cnt  = '0;
                st_d.bclk = ~st_q.bclk;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
    assign fall_o = hit && st_q.bclk;

    // R2: the divided clock moves only on an input bit-clock edge
    p_toggle_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_edge |=> $stable(bclk_o));

endmodule

// File: rtl/sas_frame_ser.sv
module sas_frame_ser
    import ser_audio_pkg::*;
#(
    parameter int DATA_W    = 20,
    parameter int SLOT_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              ws_lvl,
    input  logic              live,
    input  logic [DATA_W-1:0] left_smp,
    input  logic [DATA_W-1:0] right_smp,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        div_sel,
    input  logic              ws_regen,
    output logic              sd_o,
    output logic              ws_o,
    output logic [1:0]        div_o
);
    localparam int PW = $clog2(SLOT_BITS) + 2;
    localparam logic [PW-1:0] P_MAX  = '1;
    localparam logic [PW-1:0] P_LAST = PW'(SLOT_BITS - 1);
    localparam logic [PW-1:0] P_INIT = PW'(SLOT_BITS);

    typedef struct packed {
        cfg_t              cfg;
        logic              ws;
        logic [PW-1:0]     pos;
        logic [PW-1:0]     len;
        logic [PW-1:0]     rg;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] rsv;
        logic              bitv;
    } st_t;

    st_t st_d, st_q;
    logic ws_src, chg, boundary;

    function automatic logic pick(logic [DATA_W-1:0] w, int i);
        logic [DATA_W-1:0] t;
        t = w >> i;
        return t[0];
    endfunction

    function automatic logic slot_bit(fmt_e f, logic [PW-1:0] pos,
                                      logic [PW-1:0] len, logic [DATA_W-1:0] w);
        int p, l, k, n;
        p = int'(pos);
        l = int'(len);
        if (f == FMT_STD)
            return (p >= 1 && p <= DATA_W) ? pick(w, DATA_W - p) : 1'b0;
        n = lj_bits(f);
        if (p >= l) return 1'b0;
        k = l - 1 - p;
        if (k < n) return pick(w, DATA_W - n + k);
        return w[DATA_W-1];
    endfunction

    always_comb begin
        st_d     = st_q;
        ws_src   = st_q.cfg.regen ? ((st_q.rg >= P_LAST) ? ~st_q.ws : st_q.ws) : ws_lvl;
        chg      = ws_src ^ st_q.ws;
        boundary = chg & ~ws_src;
        if (fall) begin
            st_d.ws = ws_src;
            if (boundary) begin
                st_d.cfg = '{fmt: fmt_e'(fmt_sel), div: div_sel, regen: ws_regen};
                st_d.rsv = right_smp;
            end
            if (chg) begin
                st_d.pos  = '0;
                st_d.rg   = '0;
                st_d.len  = (st_q.pos == P_MAX) ? P_MAX : st_q.pos + 1'b1;
                st_d.word = ws_src ? st_q.rsv : left_smp;
            end else begin
                if (st_q.pos != P_MAX) st_d.pos = st_q.pos + 1'b1;
                if (st_q.rg != P_MAX)  st_d.rg  = st_q.rg + 1'b1;
            end
            st_d.bitv = slot_bit(st_d.cfg.fmt, st_d.pos, st_d.len, st_d.word);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= CFG_DEFAULT;
            st_q.len  <= P_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_o  = st_q.bitv & live;
    assign ws_o  = st_q.ws;
    assign div_o = st_q.cfg.div;

    // R8: the active configuration moves only at a frame start
    p_cfg_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall && boundary) |=> $stable(st_q.cfg));

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx #(
    parameter int DATA_W    = 20,
    parameter int SLOT_BITS = 32,
    parameter int BCLK_TMO  = 64,
    parameter int WS_TMO    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              ws_in,
    input  logic [DATA_W-1:0] left_smp,
    input  logic [DATA_W-1:0] right_smp,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        div_sel,
    input  logic              ws_regen,
    output logic              sdata_out,
    output logic              bclk_out,
    output logic              ws_out
);
    logic bclk_edge, ws_lvl, live, fall;
    logic [1:0] div_act;

    sas_in_sense #(.BCLK_TMO(BCLK_TMO), .WS_TMO(WS_TMO)) u_sense (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .ws_in(ws_in),
        .bclk_edge(bclk_edge), .ws_lvl(ws_lvl), .live(live)
    );

    sas_bclk_gen #(.DIV_W(2)) u_div (
        .clk(clk), .rst_n(rst_n), .in_edge(bclk_edge), .div_act(div_act),
        .bclk_o(bclk_out), .fall_o(fall)
    );

    sas_frame_ser #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS)) u_ser (
        .clk(clk), .rst_n(rst_n), .fall(fall), .ws_lvl(ws_lvl), .live(live),
        .left_smp(left_smp), .right_smp(right_smp), .fmt_sel(fmt_sel),
        .div_sel(div_sel), .ws_regen(ws_regen),
        .sd_o(sdata_out), .ws_o(ws_out), .div_o(div_act)
    );

    // R7: data moves only with a falling output clock, unless muting changes
    p_data_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(bclk_out) && live && $past(live)) |-> $stable(sdata_out));

    // R3: word select moves only with a falling output clock
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk_out) |-> $stable(ws_out));

endmodule

// File: tb/ser_audio_tx_tb_top.sv
module ser_audio_tx_tb_top;
    localparam int DW = 20;

    typedef struct {
        logic [1:0]    fmt;
        logic [1:0]    div;
        logic          regen;
        logic [DW-1:0] l;
        logic [DW-1:0] r;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, bclk_in, ws_in, ws_regen = 1'b0;
    logic [DW-1:0] left_smp = '0, right_smp = '0;
    logic [1:0] fmt_sel = 2'b00, div_sel = 2'b00;
    logic sdata_out, bclk_out, ws_out;

    int total = 0, bad = 0;
    bit run_b = 1'b0, run_ws = 1'b0, trk = 1'b0;
    int fstart = 0, r7_viol = 0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    ser_audio_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .ws_in(ws_in),
        .left_smp(left_smp), .right_smp(right_smp), .fmt_sel(fmt_sel),
        .div_sel(div_sel), .ws_regen(ws_regen),
        .sdata_out(sdata_out), .bclk_out(bclk_out), .ws_out(ws_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int fbits(logic [1:0] f);
        return 16 + 2 * (int'(f) - 1);
    endfunction

    function automatic logic [DW-1:0] dec(logic [63:0] s, int c, logic [1:0] f);
        logic [63:0] t;
        if (f == 2'b00) t = s >> (c - 1 - DW);
        else            t = s & ((64'd1 << fbits(f)) - 1);
        return t[DW-1:0];
    endfunction

    function automatic bit sign_ok(logic [63:0] s, int c, logic [1:0] f);
        logic [63:0] m, lead, sb;
        int n;
        if (f == 2'b00) return 1'b1;
        n    = fbits(f);
        sb   = (s >> (n - 1)) & 64'd1;
        m    = (64'd1 << (c - n)) - 1;
        lead = (s >> n) & m;
        return lead == (sb[0] ? m : 64'd0);
    endfunction

    function automatic logic [DW-1:0] expw(logic [DW-1:0] v, logic [1:0] f);
        return (f == 2'b00) ? v : (v >> (DW - fbits(f)));
    endfunction

    // input bit clock: 4 system cycles per period; word select toggles every 32 periods
    initial begin
        int hc = 0, pc = 0;
        bclk_in = 1'b0;
        ws_in   = 1'b0;
        forever begin
            @(negedge clk);
            if (run_b) begin
                hc++;
                if (hc == 2) begin
                    hc = 0;
                    bclk_in = ~bclk_in;
                    if (!bclk_in) begin
                        pc++;
                        if (pc == 32) begin
                            pc = 0;
                            if (run_ws) ws_in = ~ws_in;
                        end
                    end
                end
            end
        end
    end

    // monitor: receiver model that samples on rising bclk_out
    initial begin
        logic [63:0] sh = '0, lsh = '0;
        int cnt = 0, lcnt = 0, cyc = 0, last_rise = 0, period = 0;
        logic pb = 1'b0, psd = 1'b0, pws = 1'b0, wsr = 1'b0;
        item_t it;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (trk && (sdata_out != psd || ws_out != pws) && !(pb && !bclk_out))
                    r7_viol++;
                if (!pb && bclk_out) begin
                    period    = cyc - last_rise;
                    last_rise = cyc;
                    if (ws_out != wsr) begin
                        if (!wsr) begin
                            lsh  = sh;
                            lcnt = cnt;
                        end else begin
                            if (exp_q.size() > 0) begin
                                it = exp_q.pop_front();
                                chk(period == (4 << it.div), "R2 bclk period", period, 4 << it.div);
                                chk(lcnt == 32 && cnt == 32, it.regen ? "R4 slot length" : "R3 slot length",
                                    lcnt * 100 + cnt, 3232);
                                chk(dec(lsh, lcnt, it.fmt) == expw(it.l, it.fmt),
                                    it.fmt == 2'b00 ? "R5 left word" : "R6 left word",
                                    dec(lsh, lcnt, it.fmt), expw(it.l, it.fmt));
                                chk(dec(sh, cnt, it.fmt) == expw(it.r, it.fmt),
                                    it.fmt == 2'b00 ? "R5 right word" : "R6 right word",
                                    dec(sh, cnt, it.fmt), expw(it.r, it.fmt));
                                chk(sign_ok(lsh, lcnt, it.fmt) && sign_ok(sh, cnt, it.fmt),
                                    "R6 sign fill", {lsh[31:0], sh[31:0]}, 0);
                            end
                            fstart++;
                        end
                        sh  = {63'd0, sdata_out};
                        cnt = 1;
                        wsr = ws_out;
                    end else begin
                        sh = {sh[62:0], sdata_out};
                        cnt++;
                    end
                end
            end
            pb  = bclk_out;
            psd = sdata_out;
            pws = ws_out;
        end
    end

    task automatic wait_frames(input int n);
        repeat (n) begin
            int o = fstart;
            while (fstart == o) @(negedge clk);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] f, input logic [1:0] dv, input logic rg,
                             input logic [DW-1:0] l, input logic [DW-1:0] r);
        fmt_sel = f; div_sel = dv; ws_regen = rg; left_smp = l; right_smp = r;
        wait_frames(3);
        exp_q.push_back('{fmt: f, div: dv, regen: rg, l: l, r: r});
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ones;
        repeat (5) @(negedge clk);
        chk(!sdata_out && !bclk_out && !ws_out, "R1 outputs low in reset",
            {sdata_out, bclk_out, ws_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sdata_out && !bclk_out && !ws_out, "R1 outputs low after reset",
            {sdata_out, bclk_out, ws_out}, 0);
        run_b = 1'b1; run_ws = 1'b1;
        wait_frames(2);
        trk = 1'b1;

        // R5 / R3: I2S, pass-through word select
        run_frame(2'b00, 2'b00, 1'b0, 20'h12345, 20'hABCDE);
        // R6: three LSB-justified widths, negative and positive samples
        run_frame(2'b01, 2'b00, 1'b0, 20'h80F0F, 20'h7FFFF);
        run_frame(2'b10, 2'b00, 1'b0, 20'hC0001, 20'h2AAAA);
        run_frame(2'b11, 2'b00, 1'b0, 20'h96969, 20'h05A5A);
        // R4 / R2: regenerated word select with each divider
        run_frame(2'b00, 2'b01, 1'b1, 20'hFEDCB, 20'h00001);
        run_frame(2'b11, 2'b10, 1'b1, 20'h8ACE1, 20'h13579);
        run_frame(2'b01, 2'b11, 1'b1, 20'hFFFF0, 20'h0F0F0);

        // R8: change in mid-frame keeps the current frame in its old form
        run_frame(2'b00, 2'b00, 1'b1, 20'h11111, 20'h22222);
        wait_frames(1);
        exp_q.push_back('{fmt: 2'b00, div: 2'b00, regen: 1'b1, l: 20'h11111, r: 20'h22222});
        repeat (200) @(negedge clk);
        fmt_sel = 2'b11; left_smp = 20'hCAFE5; right_smp = 20'h3BEEF;
        drain();
        exp_q.push_back('{fmt: 2'b11, div: 2'b00, regen: 1'b1, l: 20'hCAFE5, r: 20'h3BEEF});
        drain();

        // R9: word select stalls while bit clock runs
        trk = 1'b0;
        run_frame(2'b01, 2'b00, 1'b1, 20'h80000, 20'h80000);
        run_ws = 1'b0;
        repeat (800) @(negedge clk);
        ones = 0;
        repeat (400) begin
            @(negedge clk);
            if (sdata_out) ones++;
        end
        chk(ones == 0, "R9 muted without word select", ones, 0);
        run_ws = 1'b1;
        run_frame(2'b01, 2'b00, 1'b1, 20'h80000, 20'h80000);

        // R9: bit clock stalls while data line is high
        while (!sdata_out) @(negedge clk);
        run_b = 1'b0;
        repeat (100) @(negedge clk);
        chk(!sdata_out, "R9 muted without bit clock", sdata_out, 0);
        run_b = 1'b1;
        run_frame(2'b10, 2'b00, 1'b0, 20'h4D2C1, 20'hB3E07);

        trk = 1'b1;
        run_frame(2'b00, 2'b00, 1'b0, 20'h0BEEF, 20'hF00D1);
        chk(r7_viol == 0, "R7 changes only on falling bclk_out", r7_viol, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule